// File: doc/BRIEF.md
# Phase-Slotted Shared Memory Arbiter

This block lets a processor and a second bus master, typically a display fetch engine, use one memory array without any request, grant, hold or ready signalling. A phase generator runs at the memory rate, which is twice the processor cycle rate. It splits every processor cycle into two equal halves. The processor owns the memory port in the first half. The second master owns it in the second half. Each master therefore gets exactly one memory slot per processor cycle, and the two together use the memory at its full rate.

The memory address, write data and write enable are switched by the current phase. Each master's write strobe reaches the memory only during its own slot. A strobe raised in the other slot is dropped, so neither master can corrupt the other's access. The memory is expected to return read data combinationally within a slot. At the clock edge that ends a slot, the block captures that data into a per-master read register. The register then holds its value through the following slot. A phase output goes high while the processor is off the bus. Surrounding logic uses it to run the processor clock, and any other party can use it to tell whose slot is current.

Top module: `phase_slot_arbiter`

## Requirements
- R1: While `rst` is high, `cpuOffBus` is 0 (processor slot), and `cpuRdata` and `vidRdata` are 0.
- R2: Once reset is released, `cpuOffBus` inverts on every rising clock edge, so each master gets one slot in every two memory cycles and neither ever waits.
- R3: While `cpuOffBus` is 0, `memAddr` equals `cpuAddr`, `memWdata` equals `cpuWdata`, and `memWe` equals `cpuWe`.
- R4: While `cpuOffBus` is 1, `memAddr` equals `vidAddr`, `memWdata` equals `vidWdata`, and `memWe` equals `vidWe`.
- R5: `vidWe` has no effect during the processor slot. `memWe` stays 0 there unless `cpuWe` is 1, and the location the second master addressed keeps its old contents.
- R6: `cpuWe` has no effect during the second master's slot. `memWe` stays 0 there unless `vidWe` is 1, and the location the processor addressed keeps its old contents.
- R7: At the rising edge that ends a processor slot, `cpuRdata` takes `memRdata`. It holds that value through the following second-master slot.
- R8: At the rising edge that ends a second-master slot, `vidRdata` takes `memRdata`. It holds that value through the following processor slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-rate clock (two edges per processor cycle) |
| rst | input | 1 | Synchronous active-high reset |
| cpuAddr | input | ADDR_W | Processor address |
| cpuWdata | input | DATA_W | Processor write data |
| cpuWe | input | 1 | Processor write strobe |
| cpuRdata | output | DATA_W | Processor read data, captured at the end of its slot |
| vidAddr | input | ADDR_W | Second-master address |
| vidWdata | input | DATA_W | Second-master write data |
| vidWe | input | 1 | Second-master write strobe |
| vidRdata | output | DATA_W | Second-master read data, captured at the end of its slot |
| memAddr | output | ADDR_W | Shared memory address |
| memWdata | output | DATA_W | Shared memory write data |
| memWe | output | 1 | Shared memory write enable |
| memRdata | input | DATA_W | Shared memory read data (combinational) |
| cpuOffBus | output | 1 | High while the second master owns the memory |

## Verification
The memory-side mux outputs follow the phase and the master inputs with no delay. The bench therefore drives the inputs on a falling edge and checks `memAddr`, `memWdata` and `memWe` one time unit later, in the same slot. A write lands at the rising edge that ends the slot. The captured read registers also change on that edge, so each is checked at the next falling edge, half a memory cycle later. They are checked again one full slot after that, to prove the value is held. Masked writes are checked twice: on `memWe` within the slot, and through a later read of the location that was targeted.

// File: rtl/slot_pkg.sv
package slot_pkg;
  // Strobes from the phase control to the datapath
  typedef struct packed {
    logic cpuSlot;  // processor owns the memory port this cycle
    logic capCpu;   // capture read data for the processor at the edge ending this cycle
    logic capVid;   // capture read data for the second master at the edge ending this cycle
  } slotCtl_t;
endpackage

// File: rtl/slot_phase_ctrl.sv
module slot_phase_ctrl
  import slot_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  output logic     offBus,
  output slotCtl_t ctl
);
  logic phase;  // 0 = processor slot, 1 = second-master slot

  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else     phase <= ~phase;
  end

  assign offBus     = phase;
  assign ctl.cpuSlot = ~phase;
  assign ctl.capCpu  = ~phase & ~rst;
  assign ctl.capVid  = phase & ~rst;

  // R1
  reset_slot_chk: assert property (@(posedge clk) rst |=> !offBus);

  // R2
  phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (offBus != $past(offBus)));
endmodule

// File: rtl/slot_datapath.sv
module slot_datapath
  import slot_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  slotCtl_t          ctl,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] vidAddr,
  input  logic [DATA_W-1:0] vidWdata,
  input  logic              vidWe,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [DATA_W-1:0] vidRdata
);
  always_comb begin
    if (ctl.cpuSlot) begin
      memAddr  = cpuAddr;
      memWdata = cpuWdata;
      memWe    = cpuWe & ~rst;
    end else begin
      memAddr  = vidAddr;
      memWdata = vidWdata;
      memWe    = vidWe & ~rst;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpuRdata <= '0;
      vidRdata <= '0;
    end else begin
      if (ctl.capCpu) cpuRdata <= memRdata;
      if (ctl.capVid) vidRdata <= memRdata;
    end
  end

  // R5
  vid_we_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.cpuSlot && !cpuWe) |-> !memWe);

  // R6
  cpu_we_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl.cpuSlot && !vidWe) |-> !memWe);

  // R7
  cpu_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.capCpu |=> $stable(cpuRdata));

  // R8
  vid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.capVid |=> $stable(vidRdata));
endmodule

// File: rtl/phase_slot_arbiter.sv
module phase_slot_arbiter
  import slot_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic              cpuWe,
  output logic [DATA_W-1:0] cpuRdata,
  input  logic [ADDR_W-1:0] vidAddr,
  input  logic [DATA_W-1:0] vidWdata,
  input  logic              vidWe,
  output logic [DATA_W-1:0] vidRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  input  logic [DATA_W-1:0] memRdata,
  output logic              cpuOffBus
);
  slotCtl_t ctl;

  slot_phase_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .offBus (cpuOffBus),
    .ctl    (ctl)
  );

  slot_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .cpuAddr  (cpuAddr),
    .cpuWdata (cpuWdata),
    .cpuWe    (cpuWe),
    .vidAddr  (vidAddr),
    .vidWdata (vidWdata),
    .vidWe    (vidWe),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memWe    (memWe),
    .cpuRdata (cpuRdata),
    .vidRdata (vidRdata)
  );
endmodule

// File: tb/phase_slot_arbiter_bench.sv
module phase_slot_arbiter_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] cpuAddr = '0, cpuWdata = '0, vidAddr = '0, vidWdata = '0;
  logic cpuWe = 1'b0, vidWe = 1'b0;
  logic [7:0] cpuRdata, vidRdata, memAddr, memWdata, memRdata;
  logic memWe, cpuOffBus;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  // Bench-side memory with combinational read
  logic [7:0] mem [256];
  always @(posedge clk) if (memWe) mem[memAddr] <= memWdata;
  assign memRdata = mem[memAddr];

  phase_slot_arbiter u_phase_slot_arbiter (
    .clk(clk), .rst(rst),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuWe(cpuWe), .cpuRdata(cpuRdata),
    .vidAddr(vidAddr), .vidWdata(vidWdata), .vidWe(vidWe), .vidRdata(vidRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRdata(memRdata),
    .cpuOffBus(cpuOffBus)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Advance to the next falling edge that lies inside the wanted slot
  task automatic toSlot(input logic off);
    do @(negedge clk); while (cpuOffBus !== off);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk("R1 phase", cpuOffBus, 0);
    chk("R1 cpuRdata", cpuRdata, 0);
    chk("R1 vidRdata", vidRdata, 0);
    rst = 1'b0;
  endtask

  task automatic testToggle();
    logic prev;
    @(negedge clk);
    prev = cpuOffBus;
    chk("R2 first slot after release", cpuOffBus, 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R2 alternation", cpuOffBus, {31'b0, ~prev});
      prev = cpuOffBus;
    end
  endtask

  task automatic testMux();
    toSlot(1'b0);
    cpuAddr = 8'h05; cpuWdata = 8'h77; vidAddr = 8'h09; vidWdata = 8'h88;
    #1;
    chk("R3 memAddr", memAddr, 8'h05);
    chk("R3 memWdata", memWdata, 8'h77);
    chk("R3 memWe", memWe, 0);
    toSlot(1'b1);
    #1;
    chk("R4 memAddr", memAddr, 8'h09);
    chk("R4 memWdata", memWdata, 8'h88);
  endtask

  task automatic testWritesAndMask();
    // Processor writes 0x30 <= 0x11
    toSlot(1'b0);
    cpuAddr = 8'h30; cpuWdata = 8'h11; cpuWe = 1'b1;
    #1 chk("R3 memWe follows cpuWe", memWe, 1);
    // Second master writes 0x20 <= 0x5A; processor strobe masked (R6)
    toSlot(1'b1);
    cpuWe = 1'b1; cpuAddr = 8'h10; cpuWdata = 8'hEE;
    vidAddr = 8'h20; vidWdata = 8'h5A; vidWe = 1'b1;
    #1 chk("R4 memWe follows vidWe", memWe, 1);
    // Processor writes 0x10 <= 0xA5; second master tries 0x30 <= 0xFF (R5)
    toSlot(1'b0);
    cpuAddr = 8'h10; cpuWdata = 8'hA5; cpuWe = 1'b1;
    vidAddr = 8'h30; vidWdata = 8'hFF; vidWe = 1'b1;
    #1 chk("R3 write data", memWdata, 8'hA5);
    // Second master idle, processor strobe high targets 0x20 (R6)
    toSlot(1'b1);
    vidWe = 1'b0; cpuAddr = 8'h20; cpuWdata = 8'h00; cpuWe = 1'b1;
    #1 chk("R6 memWe masked", memWe, 0);
    // Processor idle, second master strobe high targets 0x30 (R5)
    toSlot(1'b0);
    cpuWe = 1'b0; vidWe = 1'b1; vidAddr = 8'h30; vidWdata = 8'hFF;
    #1 chk("R5 memWe masked", memWe, 0);
    toSlot(1'b1);
    vidWe = 1'b0;
  endtask

  task automatic testReads();
    toSlot(1'b0);
    cpuAddr = 8'h20; vidAddr = 8'h10;
    @(negedge clk);  // second-master slot; processor capture just happened
    chk("R7 cpuRdata captured", cpuRdata, 8'h5A);
    chk("R6 location kept after masked cpu write", cpuRdata, 8'h5A);
    cpuAddr = 8'h30;
    @(negedge clk);  // processor slot; second-master capture just happened
    chk("R8 vidRdata captured", vidRdata, 8'hA5);
    chk("R7 cpuRdata held", cpuRdata, 8'h5A);
    vidAddr = 8'h20;
    @(negedge clk);
    chk("R5 location kept after masked vid write", cpuRdata, 8'h11);
    chk("R8 vidRdata held", vidRdata, 8'hA5);
    @(negedge clk);
    chk("R8 second capture", vidRdata, 8'h5A);
  endtask

  initial begin
    testReset();
    testToggle();
    testMux();
    testWritesAndMask();
    testReads();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule